// File: doc/BRIEF.md
# Crypto Capability Matcher

This block keeps a small table of cipher capability descriptors. Each descriptor holds an algorithm identifier, a key-size code and a bit mask of the data-unit sizes it accepts. Software loads descriptors through a simple write port and sets how many of them are active. A requester then presents an algorithm, a key-size code and a data-unit size in bytes, and pulses a strobe. The block answers with the lowest-numbered active descriptor that fits.

Along with the search result, the block returns the data-unit size encoded as a one-hot mask, with a flag for sizes that cannot be encoded. It also returns the key length in bytes that the requested size code implies, with a flag for codes that are not legal. The whole search is combinational over the stored table. The answer is captured in registers on the strobe edge, and a one-cycle done pulse marks it.

Top module: `cap_matcher`

## Requirements
- R1: After reset, done and found are 0 and the active count is 0, so no request can match until the count is written.
- R2: A data-unit size that is a power of two from 512 to 65536 bytes yields du_mask equal to the size divided by 512 (bit k set for 512<<k) and du_err low.
- R3: A data-unit size below 512, above 65536 or not a power of two yields du_mask 0 and du_err high, and the request never matches.
- R4: A descriptor matches only when its algorithm equals req_alg, its key-size code equals req_ksz, and its mask ANDed with du_mask is nonzero.
- R5: When several descriptors match, match_idx is the lowest matching index.
- R6: Descriptors at an index at or beyond the active count never match. With no match, found is 0 and match_idx is 0.
- R7: Key-size codes 1, 2, 3 and 4 give key_len 16, 24, 32 and 64 bytes. Any other code gives key_len 0 with key_err high.
- R8: For algorithm identifier 0 (XTS), key_len is twice the code's length. A doubled length above 64 gives key_len 0 and key_err high.
- R9: All results update on the clock edge where req_valid is high, done is high for exactly the following cycle, and the results hold until the next request.
- R10: A descriptor or count write takes effect at its clock edge and is seen by any request strobed on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one descriptor |
| wr_idx | input | 4 | Descriptor index to write |
| wr_alg | input | 8 | Algorithm identifier to store |
| wr_ksz | input | 8 | Key-size code to store |
| wr_mask | input | 8 | Accepted data-unit mask to store |
| cnt_wr_en | input | 1 | Write the active descriptor count |
| cnt_val | input | 5 | New active count (0 to 16) |
| req_valid | input | 1 | Request strobe |
| req_alg | input | 8 | Requested algorithm identifier |
| req_ksz | input | 8 | Requested key-size code |
| req_du | input | 20 | Requested data-unit size in bytes |
| done | output | 1 | One-cycle pulse after a request |
| found | output | 1 | A descriptor matched |
| match_idx | output | 4 | Lowest matching index, 0 when none |
| du_mask | output | 8 | One-hot data-unit mask |
| du_err | output | 1 | Data-unit size cannot be encoded |
| key_len | output | 7 | Key length in bytes |
| key_err | output | 1 | Key-size code or doubled length illegal |

## Verification
Every result of this block appears one clock after the edge that samples req_valid. The encoders, the table search and the output registers add up to a single register stage. The bench therefore drives a request on a falling edge, lets one rising edge capture it, and compares done, found, match_idx, du_mask, du_err, key_len and key_err at the next falling edge. It checks again one cycle later to confirm that done has dropped while the other results hold. Table and count writes are made a full cycle before the request that depends on them.

// File: rtl/cap_match_pkg.sv
package cap_match_pkg;
  parameter int unsigned ALG_W     = 8;
  parameter int unsigned KSZ_W     = 8;
  parameter int unsigned MASK_W    = 8;
  parameter int unsigned DU_W      = 20;
  parameter int unsigned KLEN_W    = 7;
  parameter int unsigned N_ENTRIES = 16;
  parameter int unsigned MIN_DU    = 512;
  parameter int unsigned MAX_KEY   = 64;
  parameter int unsigned XTS_ALG   = 0;

  typedef enum logic [KSZ_W-1:0] {
    KSZ_128 = 8'd1,
    KSZ_192 = 8'd2,
    KSZ_256 = 8'd3,
    KSZ_512 = 8'd4
  } ksz_code_e;
endpackage

// File: rtl/du_encoder.sv
module du_encoder #(
  parameter int unsigned DU_W   = cap_match_pkg::DU_W,
  parameter int unsigned MASK_W = cap_match_pkg::MASK_W,
  parameter int unsigned MIN_DU = cap_match_pkg::MIN_DU
) (
  input  logic [DU_W-1:0]   du_bytes,
  output logic [MASK_W-1:0] du_mask,
  output logic              du_err
);
  localparam int unsigned SHIFT  = $clog2(MIN_DU);
  localparam logic [DU_W-1:0] LO = DU_W'(MIN_DU);
  localparam logic [DU_W-1:0] HI = DU_W'(MIN_DU << (MASK_W - 1));

  logic pow2;
  logic legal;

  always_comb begin
    pow2    = (du_bytes != '0) && ((du_bytes & (du_bytes - 1'b1)) == '0);
    legal   = pow2 && (du_bytes >= LO) && (du_bytes <= HI);
    du_mask = legal ? MASK_W'(du_bytes >> SHIFT) : '0;
    du_err  = !legal;
    a_mask_onehot_r2: assert ($onehot0(du_mask));
  end
endmodule

// File: rtl/key_len_decoder.sv
module key_len_decoder #(
  parameter int unsigned ALG_W   = cap_match_pkg::ALG_W,
  parameter int unsigned KSZ_W   = cap_match_pkg::KSZ_W,
  parameter int unsigned KLEN_W  = cap_match_pkg::KLEN_W,
  parameter int unsigned MAX_KEY = cap_match_pkg::MAX_KEY,
  parameter int unsigned XTS_ALG = cap_match_pkg::XTS_ALG
) (
  input  logic [ALG_W-1:0]  alg,
  input  logic [KSZ_W-1:0]  ksz,
  output logic [KLEN_W-1:0] key_len,
  output logic              key_err
);
  import cap_match_pkg::*;
  localparam int unsigned SUM_W = KLEN_W + 1;

  logic [SUM_W-1:0] base_len;
  logic [SUM_W-1:0] total_len;

  always_comb begin
    unique case (ksz)
      KSZ_128: base_len = SUM_W'(16);
      KSZ_192: base_len = SUM_W'(24);
      KSZ_256: base_len = SUM_W'(32);
      KSZ_512: base_len = SUM_W'(64);
      default: base_len = '0;
    endcase
    total_len = (alg == ALG_W'(XTS_ALG)) ? (base_len << 1) : base_len;
    key_err   = (base_len == '0) || (total_len > SUM_W'(MAX_KEY));
    key_len   = key_err ? '0 : KLEN_W'(total_len);
    a_len_bound_r8: assert (key_err || (key_len != '0 && key_len <= KLEN_W'(MAX_KEY)));
  end
endmodule

// File: rtl/cap_table.sv
module cap_table #(
  parameter int unsigned N_ENTRIES = cap_match_pkg::N_ENTRIES,
  parameter int unsigned ALG_W     = cap_match_pkg::ALG_W,
  parameter int unsigned KSZ_W     = cap_match_pkg::KSZ_W,
  parameter int unsigned MASK_W    = cap_match_pkg::MASK_W,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ALG_W-1:0]  wr_alg,
  input  logic [KSZ_W-1:0]  wr_ksz,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [CNT_W-1:0]  active_cnt,
  input  logic [ALG_W-1:0]  q_alg,
  input  logic [KSZ_W-1:0]  q_ksz,
  input  logic [MASK_W-1:0] q_mask,
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [N_ENTRIES-1:0] hit;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    logic [ALG_W-1:0]  alg_q;
    logic [KSZ_W-1:0]  ksz_q;
    logic [MASK_W-1:0] mask_q;
    logic              load;

    assign load = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alg_q  <= '0;
        ksz_q  <= '0;
        mask_q <= '0;
      end else if (load) begin
        alg_q  <= wr_alg;
        ksz_q  <= wr_ksz;
        mask_q <= wr_mask;
      end
    end

    assign hit[e] = (CNT_W'(e) < active_cnt) && (alg_q == q_alg) &&
                    (ksz_q == q_ksz) && ((mask_q & q_mask) != '0);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
    hit_any = |hit;
  end
endmodule

// File: rtl/cap_matcher.sv
module cap_matcher #(
  parameter int unsigned N_ENTRIES = cap_match_pkg::N_ENTRIES,
  parameter int unsigned ALG_W     = cap_match_pkg::ALG_W,
  parameter int unsigned KSZ_W     = cap_match_pkg::KSZ_W,
  parameter int unsigned MASK_W    = cap_match_pkg::MASK_W,
  parameter int unsigned DU_W      = cap_match_pkg::DU_W,
  parameter int unsigned KLEN_W    = cap_match_pkg::KLEN_W,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ALG_W-1:0]  wr_alg,
  input  logic [KSZ_W-1:0]  wr_ksz,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              req_valid,
  input  logic [ALG_W-1:0]  req_alg,
  input  logic [KSZ_W-1:0]  req_ksz,
  input  logic [DU_W-1:0]   req_du,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  match_idx,
  output logic [MASK_W-1:0] du_mask,
  output logic              du_err,
  output logic [KLEN_W-1:0] key_len,
  output logic              key_err
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MASK_W-1:0] mask_c;
  logic              du_err_c;
  logic [KLEN_W-1:0] klen_c;
  logic              kerr_c;
  logic              hit_c;
  logic [IDX_W-1:0]  idx_c;

  du_encoder #(.DU_W(DU_W), .MASK_W(MASK_W)) i_du_enc (
    .du_bytes(req_du), .du_mask(mask_c), .du_err(du_err_c)
  );

  key_len_decoder #(.ALG_W(ALG_W), .KSZ_W(KSZ_W), .KLEN_W(KLEN_W)) i_klen (
    .alg(req_alg), .ksz(req_ksz), .key_len(klen_c), .key_err(kerr_c)
  );

  cap_table #(.N_ENTRIES(N_ENTRIES), .ALG_W(ALG_W), .KSZ_W(KSZ_W),
              .MASK_W(MASK_W)) i_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_alg(wr_alg), .wr_ksz(wr_ksz), .wr_mask(wr_mask),
    .active_cnt(cnt_q), .q_alg(req_alg), .q_ksz(req_ksz), .q_mask(mask_c),
    .hit_any(hit_c), .hit_idx(idx_c)
  );

  always_comb begin
    cnt_d = cnt_wr_en ? cnt_val : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found     <= 1'b0;
      match_idx <= '0;
      du_mask   <= '0;
      du_err    <= 1'b0;
      key_len   <= '0;
      key_err   <= 1'b0;
    end else if (req_valid) begin
      found     <= hit_c;
      match_idx <= idx_c;
      du_mask   <= mask_c;
      du_err    <= du_err_c;
      key_len   <= klen_c;
      key_err   <= kerr_c;
    end
  end

  p_done_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(found) && $stable(match_idx) && $stable(key_len));
  p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!found || (CNT_W'(match_idx) < $past(cnt_q))));
  p_bad_du_no_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    du_err |-> (!found && du_mask == '0));
  p_miss_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> match_idx == '0);
  p_key_err_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |-> key_len == '0);
endmodule

// File: tb/test_cap_matcher.sv
module test_cap_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, cnt_wr_en, req_valid;
  logic [3:0]  wr_idx;
  logic [7:0]  wr_alg, wr_ksz, wr_mask, req_alg, req_ksz;
  logic [4:0]  cnt_val;
  logic [19:0] req_du;
  logic        done, found, du_err, key_err;
  logic [3:0]  match_idx;
  logic [7:0]  du_mask;
  logic [6:0]  key_len;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cap_matcher i_cap_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_alg(wr_alg), .wr_ksz(wr_ksz), .wr_mask(wr_mask),
    .cnt_wr_en(cnt_wr_en), .cnt_val(cnt_val), .req_valid(req_valid),
    .req_alg(req_alg), .req_ksz(req_ksz), .req_du(req_du), .done(done),
    .found(found), .match_idx(match_idx), .du_mask(du_mask),
    .du_err(du_err), .key_len(key_len), .key_err(key_err)
  );

  typedef struct packed {
    logic [7:0]  alg;
    logic [7:0]  ksz;
    logic [19:0] du;
    logic        f;
    logic [3:0]  idx;
    logic [7:0]  mask;
    logic        derr;
    logic [6:0]  klen;
    logic        kerr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 8'd1, 20'd512,    1'b1, 4'd0, 8'h01, 1'b0, 7'd16, 1'b0}, // R4 R2
    '{8'd2, 8'd1, 20'd1024,   1'b1, 4'd3, 8'h02, 1'b0, 7'd16, 1'b0}, // R4 mask overlap
    '{8'd0, 8'd3, 20'd4096,   1'b1, 4'd1, 8'h08, 1'b0, 7'd64, 1'b0}, // R8 XTS 256
    '{8'd0, 8'd3, 20'd512,    1'b1, 4'd2, 8'h01, 1'b0, 7'd64, 1'b0}, // R5
    '{8'd3, 8'd2, 20'd65536,  1'b1, 4'd4, 8'h80, 1'b0, 7'd24, 1'b0}, // R2 top size
    '{8'd1, 8'd4, 20'd512,    1'b0, 4'd0, 8'h01, 1'b0, 7'd64, 1'b0}, // R6 beyond count
    '{8'd0, 8'd4, 20'd512,    1'b0, 4'd0, 8'h01, 1'b0, 7'd0,  1'b1}, // R8 XTS 512 err
    '{8'd2, 8'd1, 20'd768,    1'b0, 4'd0, 8'h00, 1'b1, 7'd16, 1'b0}, // R3 non pow2
    '{8'd2, 8'd1, 20'd256,    1'b0, 4'd0, 8'h00, 1'b1, 7'd16, 1'b0}, // R3 too small
    '{8'd2, 8'd1, 20'd131072, 1'b0, 4'd0, 8'h00, 1'b1, 7'd16, 1'b0}, // R3 too large
    '{8'd2, 8'd5, 20'd512,    1'b0, 4'd0, 8'h01, 1'b0, 7'd0,  1'b1}, // R7 bad code
    '{8'd2, 8'd0, 20'd512,    1'b0, 4'd0, 8'h01, 1'b0, 7'd0,  1'b1}, // R7 code 0
    '{8'd0, 8'd1, 20'd512,    1'b0, 4'd0, 8'h01, 1'b0, 7'd32, 1'b0}, // R8 XTS 128
    '{8'd3, 8'd2, 20'd32768,  1'b0, 4'd0, 8'h40, 1'b0, 7'd24, 1'b0}, // R4 no overlap
    '{8'd0, 8'd2, 20'd2048,   1'b0, 4'd0, 8'h04, 1'b0, 7'd48, 1'b0}  // R8 XTS 192
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input int alg, input int ksz, input int mask);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_alg = 8'(alg); wr_ksz = 8'(ksz); wr_mask = 8'(mask);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_count(input int c);
    @(negedge clk);
    cnt_wr_en = 1'b1; cnt_val = 5'(c);
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  task automatic request(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_alg = v.alg; req_ksz = v.ksz; req_du = v.du;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    chk({tag, " R9 done"}, 32'(done), 32'd1);
    chk({tag, " R4 found"}, 32'(found), 32'(v.f));
    chk({tag, " R5 match_idx"}, 32'(match_idx), 32'(v.idx));
    chk({tag, " R2 du_mask"}, 32'(du_mask), 32'(v.mask));
    chk({tag, " R3 du_err"}, 32'(du_err), 32'(v.derr));
    chk({tag, " R7 key_len"}, 32'(key_len), 32'(v.klen));
    chk({tag, " R8 key_err"}, 32'(key_err), 32'(v.kerr));
  endtask

  initial begin
    #2_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0; wr_en = 1'b0; cnt_wr_en = 1'b0; req_valid = 1'b0;
    wr_idx = '0; wr_alg = '0; wr_ksz = '0; wr_mask = '0; cnt_val = '0;
    req_alg = '0; req_ksz = '0; req_du = '0;
    repeat (3) @(negedge clk);
    chk("R1 done at reset", 32'(done), 32'd0);
    chk("R1 found at reset", 32'(found), 32'd0);
    rst_n = 1'b1;

    // R1: count is 0 after reset, so even a loaded entry cannot match
    write_entry(0, 2, 1, 1);
    request(VECS[0]);
    chk("R1 no match with count 0", 32'(found), 32'd0);
    chk("R9 done after request", 32'(done), 32'd1);

    // R10: table load
    write_entry(1, 0, 3, 8'h08);
    write_entry(2, 0, 3, 8'h01);
    write_entry(3, 2, 1, 8'h03);
    write_entry(4, 3, 2, 8'h80);
    write_entry(5, 0, 3, 8'h09);
    write_entry(6, 1, 4, 8'hFF);
    set_count(6);

    for (int k = 0; k < NV; k++) begin
      request(VECS[k]);
      check_vec(VECS[k], $sformatf("vec%0d", k));
    end

    // R9: done single cycle, results hold
    @(negedge clk);
    chk("R9 done drops", 32'(done), 32'd0);
    chk("R9 key_len holds", 32'(key_len), 32'd48);
    chk("R9 du_mask holds", 32'(du_mask), 32'h04);

    // R6 / R10: raise count to 7, entry 6 now visible
    set_count(7);
    request(VECS[5]);
    chk("R6 entry 6 visible after count 7", 32'(found), 32'd1);
    chk("R6 entry 6 index", 32'(match_idx), 32'd6);

    // R5 / R10: rewrite entry 0 so 1024 also fits there
    write_entry(0, 2, 1, 8'h02);
    request(VECS[1]);
    chk("R5 lowest index after rewrite", 32'(match_idx), 32'd0);
    chk("R10 rewrite found", 32'(found), 32'd1);

    // R6: count 0 again -> nothing matches
    set_count(0);
    request(VECS[1]);
    chk("R6 count 0 found", 32'(found), 32'd0);
    chk("R6 count 0 idx", 32'(match_idx), 32'd0);

    // R3: zero size
    v = VECS[0]; v.du = 20'd0;
    request(v);
    chk("R3 zero size du_err", 32'(du_err), 32'd1);
    chk("R3 zero size mask", 32'(du_mask), 32'd0);

    // R1: reset mid-run clears outputs
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 found after reset", 32'(found), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule